// File: doc/BRIEF.md
# Bus Cycle Watchdog with Error Acknowledge

This block watches every processor bus cycle between the rising and the falling of the address strobe. A timeout counter advances only on a 4 MHz count-enable pulse. If no transfer acknowledge arrives within sixteen of those pulses (4.0 µs, fixed), the block raises a bus error so that the processor can abandon the cycle.

Error-control logic can block a cycle. It does so when an access violation is flagged during the cycle itself, or when a parity error was flagged during the cycle before it. A blocked cycle never drives its strobe onto the system bus, so no slave can answer it. When such a cycle times out, the block does not raise a bus error. It records the fault in a sticky status bit and drives a substitute acknowledge, so the processor finishes the cycle in the normal way. Software later reads the status bit and clears it with a write pulse.

The control core is a five-state machine:

- `BW_IDLE`: the strobe is negated.
- `BW_WAIT`: counting towards the timeout.
- `BW_ACKED`: a real acknowledge arrived and the counter is frozen.
- `BW_BERR`: bus error is asserted.
- `BW_SUBACK`: the substitute acknowledge is asserted.

The transitions are:

- IDLE→WAIT when the strobe rises without an acknowledge.
- IDLE→ACKED when the strobe rises with an acknowledge.
- WAIT→ACKED when an acknowledge arrives.
- WAIT→BERR on expiry of an unblocked cycle.
- WAIT→SUBACK on expiry of a blocked cycle.
- Any state→IDLE when the strobe is negated.

Top module: `bus_watchdog`

## Requirements
- R1: After reset, `bus_err`, `sub_ack` and `err_status` are 0, and no cycle is in progress.
- R2: Count-enable pulses that occur while `as_in` is 0 do not advance the timeout, so a cycle that starts after idle pulses still needs its full sixteen pulses.
- R3: In a cycle that is not blocked and receives no acknowledge, `bus_err` goes to 1 on the clock after the 16th `tick` pulse counted while `as_in` is 1. After only 15 pulses it stays 0. Only a cycle with `tick` 1 can move `bus_err` from 0 to 1.
- R4: Once `ack_in` is seen at 1 during a cycle, neither `bus_err` nor `sub_ack` is raised in that cycle, whatever number of further pulses follow.
- R5: `as_out` equals `as_in`, except that it is 0 in every cycle of a bus cycle where `access_viol` is 1, and from that point until `as_in` falls.
- R6: A `parity_err` pulse seen in one bus cycle, or while idle before the next strobe, blocks the next bus cycle: that cycle's `as_out` stays 0. The cycle after that one is not blocked.
- R7: When a blocked cycle times out, `bus_err` stays 0. Instead `sub_ack` goes to 1 and `err_status` goes to 1, on the same clock at which an unblocked cycle would raise `bus_err`. `bus_err` and `sub_ack` are never 1 together.
- R8: `bus_err` and `sub_ack` stay at 1 while `as_in` stays at 1. Both are 0 on the clock after `as_in` is seen at 0.
- R9: `err_status` stays at 1 across later cycles until `status_clr` is seen at 1, which clears it on the next clock. A new blocked timeout in the same clock takes priority over the clear.
- R10: Each new cycle restarts the timeout from zero, so two back-to-back unanswered cycles each need sixteen pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_in | input | 1 | Address strobe from the processor, 1 = asserted |
| ack_in | input | 1 | Transfer acknowledge from the bus, 1 = asserted |
| tick | input | 1 | One-clock count-enable pulse at 4 MHz |
| access_viol | input | 1 | Access violation flagged for the current cycle |
| parity_err | input | 1 | Parity error flagged, applies to the following cycle |
| status_clr | input | 1 | Write pulse that clears the latched error status |
| as_out | output | 1 | Gated address strobe driven to the bus |
| bus_err | output | 1 | Bus error to the processor |
| sub_ack | output | 1 | Substitute acknowledge for a blocked cycle |
| err_status | output | 1 | Sticky error status, readable by the processor |

## Verification
The assertions assume the following about the inputs:

- `tick` is a single-clock pulse.
- `ack_in` only matters while `as_in` is high.
- `as_in` stays asserted until the cycle has been answered by a real acknowledge, a bus error or the substitute acknowledge.

The stimulus follows the same rules. The strobe is held high until the expected outcome has been observed. Count-enable pulses are separated by idle clocks. Acknowledge, access-violation and parity flags are changed only between clock edges, and never in the clock where the strobe rises unless that coincidence is the point of the test.

// File: rtl/bus_watchdog_pkg.sv
package bus_watchdog_pkg;

    typedef enum logic [2:0] {
        BW_IDLE   = 3'd0,
        BW_WAIT   = 3'd1,
        BW_ACKED  = 3'd2,
        BW_BERR   = 3'd3,
        BW_SUBACK = 3'd4
    } bw_state_e;

endpackage

// File: rtl/bw_timer.sv
module bw_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counter is held at zero whenever the strobe is negated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && tick && (cnt_q == LAST);

endmodule

// File: rtl/bw_gate.sv
module bw_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic as_in,
    input  logic cycle_start,
    input  logic access_viol,
    input  logic parity_err,
    output logic as_out,
    output logic blocked
);
    logic par_pend_q;
    logic block_q;

    // Parity flag waits for the next strobe, where it is consumed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_pend_q <= 1'b0;
        end else if (cycle_start) begin
            par_pend_q <= parity_err;
        end else if (parity_err) begin
            par_pend_q <= 1'b1;
        end
    end

    // Once a cycle is blocked it stays blocked until the strobe drops.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            block_q <= 1'b0;
        end else if (!as_in) begin
            block_q <= 1'b0;
        end else if (cycle_start) begin
            block_q <= access_viol || par_pend_q;
        end else if (access_viol) begin
            block_q <= 1'b1;
        end
    end

    assign blocked = block_q || access_viol || (cycle_start && par_pend_q);
    assign as_out  = as_in && !blocked;

endmodule

// File: rtl/bw_fsm.sv
module bw_fsm
    import bus_watchdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      as_in,
    input  logic      ack_in,
    input  logic      expire,
    input  logic      blocked,
    output bw_state_e state,
    output logic      bus_err,
    output logic      sub_ack,
    output logic      fault_set
);
    bw_state_e state_q;
    bw_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!as_in) begin
            state_d = BW_IDLE;
        end else begin
            unique case (state_q)
                BW_IDLE:   state_d = ack_in ? BW_ACKED : BW_WAIT;
                BW_WAIT: begin
                    if (ack_in) begin
                        state_d = BW_ACKED;
                    end else if (expire) begin
                        state_d = blocked ? BW_SUBACK : BW_BERR;
                    end
                end
                BW_ACKED:  state_d = BW_ACKED;
                BW_BERR:   state_d = BW_BERR;
                BW_SUBACK: state_d = BW_SUBACK;
                default:   state_d = BW_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_err   = 1'b0;
        sub_ack   = 1'b0;
        fault_set = 1'b0;
        unique case (state_q)
            BW_BERR:   bus_err = 1'b1;
            BW_SUBACK: sub_ack = 1'b1;
            default: ;
        endcase
        if (state_q == BW_WAIT && state_d == BW_SUBACK) begin
            fault_set = 1'b1;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import bus_watchdog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_in,
    input  logic ack_in,
    input  logic tick,
    input  logic access_viol,
    input  logic parity_err,
    input  logic status_clr,
    output logic as_out,
    output logic bus_err,
    output logic sub_ack,
    output logic err_status
);
    bw_state_e state;
    logic      expire;
    logic      blocked;
    logic      fault_set;
    logic      cycle_start;
    logic      status_q;

    assign cycle_start = as_in && (state == BW_IDLE);

    bw_timer #(.LIMIT(TIMEOUT_TICKS)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!as_in),
        .run    (state == BW_WAIT),
        .tick   (tick),
        .expire (expire)
    );

    bw_gate gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_in       (as_in),
        .cycle_start (cycle_start),
        .access_viol (access_viol),
        .parity_err  (parity_err),
        .as_out      (as_out),
        .blocked     (blocked)
    );

    bw_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_in     (as_in),
        .ack_in    (ack_in),
        .expire    (expire),
        .blocked   (blocked),
        .state     (state),
        .bus_err   (bus_err),
        .sub_ack   (sub_ack),
        .fault_set (fault_set)
    );

    // Sticky status: a new fault wins over a simultaneous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (fault_set) begin
            status_q <= 1'b1;
        end else if (status_clr) begin
            status_q <= 1'b0;
        end
    end

    assign err_status = status_q;

endmodule

// File: rtl/bus_watchdog_chk.sv
module bus_watchdog_chk (
    input logic clk,
    input logic rst_n,
    input logic as_in,
    input logic ack_in,
    input logic tick,
    input logic access_viol,
    input logic status_clr,
    input logic as_out,
    input logic bus_err,
    input logic sub_ack,
    input logic err_status
);
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_err && sub_ack));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_err || sub_ack) && as_in) |=> (bus_err || sub_ack));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        !as_in |=> (!bus_err && !sub_ack));

    a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
        as_out |-> (as_in && !access_viol));

    a_r4_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && as_in && !bus_err && !sub_ack) |=> (!bus_err && !sub_ack));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !status_clr) |=> err_status);

    a_r3_tick_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(tick));

    a_r7_status_with_suback: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_ack) |-> err_status);

endmodule

bind bus_watchdog bus_watchdog_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_in       (as_in),
    .ack_in      (ack_in),
    .tick        (tick),
    .access_viol (access_viol),
    .status_clr  (status_clr),
    .as_out      (as_out),
    .bus_err     (bus_err),
    .sub_ack     (sub_ack),
    .err_status  (err_status)
);

// File: tb/bus_watchdog_tb_top.sv
module bus_watchdog_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_in = 1'b0;
    logic ack_in = 1'b0;
    logic tick = 1'b0;
    logic access_viol = 1'b0;
    logic parity_err = 1'b0;
    logic status_clr = 1'b0;
    logic as_out;
    logic bus_err;
    logic sub_ack;
    logic err_status;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bus_watchdog #(.TIMEOUT_TICKS(16)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_in       (as_in),
        .ack_in      (ack_in),
        .tick        (tick),
        .access_viol (access_viol),
        .parity_err  (parity_err),
        .status_clr  (status_clr),
        .as_out      (as_out),
        .bus_err     (bus_err),
        .sub_ack     (sub_ack),
        .err_status  (err_status)
    );

    // Vector fields: {av, pe, ack, ticks[4:0], exp_as_out, exp_berr, exp_sub, exp_status}
    localparam int NV = 8;
    localparam logic [11:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 1'b0, 5'd16, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 5'd15, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b1, 5'd8,  1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 5'd16, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 1'b0, 5'd16, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b0, 1'b0, 5'd16, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 5'd15, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b1, 5'd4,  1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            step();
        end
    endtask

    task automatic end_cycle();
        as_in = 1'b0;
        ack_in = 1'b0;
        access_viol = 1'b0;
        step();
    endtask

    task automatic clear_status();
        status_clr = 1'b1;
        step();
        status_clr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        // R1 reset state
        check(bus_err, 1'b0, "R1 bus_err after reset");
        check(sub_ack, 1'b0, "R1 sub_ack after reset");
        check(err_status, 1'b0, "R1 err_status after reset");
        rst_n = 1'b1;
        step();

        for (int v = 0; v < NV; v++) begin
            logic [11:0] e;
            e = VEC[v];
            if (e[10]) begin
                parity_err = 1'b1;
                step();
                parity_err = 1'b0;
                step();
            end
            access_viol = e[11];
            as_in = 1'b1;
            #1;
            check(as_out, e[3], $sformatf("R5 R6 strobe gate vector %0d", v));
            step();
            pulses(int'(e[8:4]));
            if (e[9]) begin
                ack_in = 1'b1;
                step();
                pulses(20);
            end
            step();
            check(bus_err, e[2], $sformatf("R3 R4 bus_err vector %0d", v));
            check(sub_ack, e[1], $sformatf("R7 sub_ack vector %0d", v));
            check(err_status, e[0], $sformatf("R7 err_status vector %0d", v));
            end_cycle();
            check(bus_err, 1'b0, $sformatf("R8 bus_err release vector %0d", v));
            check(sub_ack, 1'b0, $sformatf("R8 sub_ack release vector %0d", v));
            step();
            check(err_status, e[0], $sformatf("R9 status sticky vector %0d", v));
            clear_status();
            check(err_status, 1'b0, $sformatf("R9 status cleared vector %0d", v));
            step();
        end

        // R2: idle pulses are not counted
        pulses(10);
        as_in = 1'b1;
        step();
        pulses(15);
        step();
        check(bus_err, 1'b0, "R2 idle pulses ignored");
        pulses(1);
        check(bus_err, 1'b1, "R2 full count still needed");
        // R8: error holds while strobe stays high
        pulses(5);
        check(bus_err, 1'b1, "R8 bus_err holds");
        end_cycle();
        step();

        // R10: back-to-back cycles each restart from zero
        as_in = 1'b1;
        step();
        pulses(16);
        check(bus_err, 1'b1, "R10 first cycle expires");
        end_cycle();
        as_in = 1'b1;
        step();
        pulses(15);
        check(bus_err, 1'b0, "R10 second cycle restarted");
        pulses(1);
        check(bus_err, 1'b1, "R10 second cycle expires");
        end_cycle();
        step();

        // R6: parity pulse inside a cycle blocks the next cycle only
        as_in = 1'b1;
        step();
        parity_err = 1'b1;
        step();
        parity_err = 1'b0;
        ack_in = 1'b1;
        step();
        end_cycle();
        as_in = 1'b1;
        #1;
        check(as_out, 1'b0, "R6 next cycle blocked");
        step();
        pulses(16);
        check(sub_ack, 1'b1, "R6 R7 blocked cycle gets sub_ack");
        check(bus_err, 1'b0, "R7 no bus_err on blocked");
        end_cycle();
        as_in = 1'b1;
        #1;
        check(as_out, 1'b1, "R6 following cycle not blocked");
        ack_in = 1'b1;
        step();
        end_cycle();

        // R5: violation raised mid-cycle drops the strobe until the end
        as_in = 1'b1;
        step();
        #1;
        check(as_out, 1'b1, "R5 strobe passes");
        access_viol = 1'b1;
        #1;
        check(as_out, 1'b0, "R5 strobe dropped on violation");
        step();
        access_viol = 1'b0;
        #1;
        check(as_out, 1'b0, "R5 strobe stays dropped");
        // R9: fault wins over a simultaneous clear
        pulses(15);
        status_clr = 1'b1;
        tick = 1'b1;
        step();
        tick = 1'b0;
        status_clr = 1'b0;
        check(err_status, 1'b1, "R9 set wins over clear");
        check(sub_ack, 1'b1, "R7 sub_ack after mid-cycle violation");
        end_cycle();
        clear_status();
        check(err_status, 1'b0, "R9 clear after fault");

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule